// File: doc/BRIEF.md
# Prioritised Interrupt Delivery Interface

This block sits between a handful of level-sensitive peripheral interrupt requests and one processor core. Each source has its own priority value and its own enable bit. The block keeps, for every source, whether it is waiting and whether it is being serviced. It raises a single interrupt line whenever a waiting, enabled source is more urgent than the work the core is already doing.

The core talks to the block through two register-style accesses. The first is an acknowledge read. It returns the identifier of the winning source, and that read alone moves the source into service. The second is an end-of-interrupt write that carries the same identifier back and retires it. Interrupts can nest. A strictly more urgent source may interrupt a handler that is already running, and each retirement brings back the running priority of the handler underneath.

Top module: `irq_cpu_if`

## Requirements
- R1: After reset, `irq_o` is 0, `run_prio` equals 2^PRIO_W (idle, 16 by default), and `ack_id` presents the spurious identifier 1023.
- R2: A request held high on `src_req` appears as a waiting source one rising edge after it is first sampled high. If that source is enabled and eligible, `irq_o` is 1 from then on.
- R3: The source offered on `ack_id` is the waiting, enabled source with the numerically smallest priority value. Between equal values, the smallest source index wins. Source i reads back as identifier i.
- R4: A source whose `src_en` bit is 0 is never offered, and it never raises `irq_o`. Its request is still held, so setting the enable bit makes the source eligible at once.
- R5: `ack_rd` high at a rising edge while `irq_o` is 1 puts the offered source into service. After that edge, `run_prio` equals that source's priority, and the source is no longer offered.
- R6: `ack_rd` while `irq_o` is 0 returns 1023 and changes neither `run_prio` nor the service state.
- R7: While a source is in service, `irq_o` is raised only for a waiting source whose priority value is strictly smaller than `run_prio`.
- R8: `eoi_wr` with `eoi_id` equal to the most recently acknowledged source that is still in service retires that source. `run_prio` goes back to the previous level (or idle), and the source may be offered again if its request is still high.
- R9: `eoi_wr` with any other identifier is ignored. This covers a source that is not in service and an outer, earlier-acknowledged one.
- R10: At most DEPTH sources (4 by default) are in service at once. At that depth, `irq_o` stays 0 and an acknowledge read returns 1023.
- R11: If `ack_rd` takes a source at the same edge as an `eoi_wr`, the acknowledgement is carried out and the end-of-interrupt write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| src_req | input | N_SRC | Level-sensitive request per source |
| src_en | input | N_SRC | Per-source enable |
| src_prio | input | N_SRC*PRIO_W | Priority of source i in bits [i*PRIO_W +: PRIO_W]; a lower value is more urgent |
| irq_o | output | 1 | Interrupt line to the core |
| ack_rd | input | 1 | Acknowledge read strobe |
| ack_id | output | 10 | Identifier returned by the acknowledge read (1023 = spurious) |
| eoi_wr | input | 1 | End-of-interrupt write strobe |
| eoi_id | input | 10 | Identifier carried by the end-of-interrupt write |
| run_prio | output | PRIO_W+1 | Priority of the innermost source in service; 2^PRIO_W when idle |

## Verification
A request change shows up on `irq_o` and `ack_id` one rising edge after it is sampled, because the request passes through one register. A change to an enable bit or to a priority shows up in the same cycle. The response to an acknowledge read is presented combinationally while `ack_rd` is high. That read and every end-of-interrupt write update `irq_o`, `run_prio` and the offered identifier exactly one edge later. The bench drives every input at the falling edge and captures `ack_id` shortly before the capturing rising edge. It reads the other outputs one time step after the following falling edge, so each check lands in the first cycle in which its result is due.

// File: rtl/irq_cif_pkg.sv
package irq_cif_pkg;

    localparam int INTID_W    = 10;
    localparam int PRIO_MAX_W = 8;

    typedef logic [INTID_W-1:0]  intid_t;
    typedef logic [PRIO_MAX_W-1:0] prio_t;
    typedef logic [PRIO_MAX_W:0] rprio_t;

    localparam intid_t SPURIOUS_ID = intid_t'(1023);

    // One level of the in-service nesting record
    typedef struct packed {
        intid_t id;
        prio_t  prio;
    } act_ent_t;

    // Arbitration winner
    typedef struct packed {
        logic   valid;
        intid_t id;
        prio_t  prio;
    } cand_t;

    // Idle running priority: one above the least urgent programmable value
    function automatic rprio_t idle_prio(int prio_w);
        return rprio_t'(1) << prio_w;
    endfunction

    // Candidate strictly more urgent than what is running
    function automatic logic cand_preempts(cand_t c, rprio_t running);
        return c.valid && (rprio_t'(c.prio) < running);
    endfunction

endpackage

// File: rtl/irq_src_state.sv
module irq_src_state #(
    parameter int N_SRC = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_SRC-1:0] req_i,
    input  logic [N_SRC-1:0] act_set_i,
    input  logic [N_SRC-1:0] act_clr_i,
    output logic [N_SRC-1:0] pend_o,
    output logic [N_SRC-1:0] act_o
);

    logic [N_SRC-1:0] req_q;
    logic [N_SRC-1:0] act_q;

    for (genvar g = 0; g < N_SRC; g++) begin : g_src
        always_ff @(posedge clk) begin
            if (rst) begin
                req_q[g] <= 1'b0;
                act_q[g] <= 1'b0;
            end else begin
                req_q[g] <= req_i[g];
                if (act_set_i[g])
                    act_q[g] <= 1'b1;
                else if (act_clr_i[g])
                    act_q[g] <= 1'b0;
            end
        end
    end

    assign pend_o = req_q & ~act_q;
    assign act_o  = act_q;

    // Only one source enters service per acknowledge (R5)
    assert_single_ack_R5: assert property (@(posedge clk) disable iff (rst)
        $onehot0(act_set_i));

    // A source entering service was not already in service (R5)
    assert_no_double_entry_R5: assert property (@(posedge clk) disable iff (rst)
        ((act_set_i & act_q) == '0));

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
    import irq_cif_pkg::*;
#(
    parameter int N_SRC  = 8,
    parameter int PRIO_W = 4
) (
    input  logic [N_SRC-1:0]        mask_i,
    input  logic [N_SRC*PRIO_W-1:0] prio_i,
    output cand_t                   cand_o
);

    always_comb begin
        cand_t best;
        prio_t p;
        best = '0;
        for (int i = 0; i < N_SRC; i++) begin
            p = prio_t'(prio_i[i*PRIO_W +: PRIO_W]);
            // strict compare keeps the lower index on ties
            if (mask_i[i] && (!best.valid || p < best.prio)) begin
                best.valid = 1'b1;
                best.id    = intid_t'(i);
                best.prio  = p;
            end
        end
        cand_o = best;
    end

endmodule

// File: rtl/irq_active_stack.sv
module irq_active_stack
    import irq_cif_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       push_i,
    input  act_ent_t   push_ent_i,
    input  logic       pop_i,
    output logic       empty_o,
    output logic       full_o,
    output act_ent_t   top_o,
    output logic [CNT_W-1:0] count_o
);

    act_ent_t         slot_q [DEPTH];
    logic [CNT_W-1:0] cnt_q;

    assign empty_o = (cnt_q == '0);
    assign full_o  = (cnt_q == CNT_W'(DEPTH));
    assign count_o = cnt_q;

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst)
                slot_q[g] <= '0;
            else if (push_i && !full_o && cnt_q == CNT_W'(g))
                slot_q[g] <= push_ent_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (push_i && !full_o)
            cnt_q <= cnt_q + 1'b1;
        else if (pop_i && !empty_o)
            cnt_q <= cnt_q - 1'b1;
    end

    always_comb begin
        top_o = '0;
        for (int g = 0; g < DEPTH; g++)
            if (cnt_q == CNT_W'(g + 1))
                top_o = slot_q[g];
    end

    // Nesting never exceeds the configured depth (R10)
    assert_no_overflow_R10: assert property (@(posedge clk) disable iff (rst)
        push_i |-> !full_o);

    // Retirement only happens with something in service (R8)
    assert_no_underflow_R8: assert property (@(posedge clk) disable iff (rst)
        pop_i |-> !empty_o);

    // Acknowledge and retirement never act in the same edge (R11)
    assert_push_pop_excl_R11: assert property (@(posedge clk) disable iff (rst)
        !(push_i && pop_i));

endmodule

// File: rtl/irq_cpu_if.sv
module irq_cpu_if
    import irq_cif_pkg::*;
#(
    parameter int N_SRC  = 8,
    parameter int PRIO_W = 4,
    parameter int DEPTH  = 4
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [N_SRC-1:0]        src_req,
    input  logic [N_SRC-1:0]        src_en,
    input  logic [N_SRC*PRIO_W-1:0] src_prio,
    output logic                    irq_o,
    input  logic                    ack_rd,
    output logic [INTID_W-1:0]      ack_id,
    input  logic                    eoi_wr,
    input  logic [INTID_W-1:0]      eoi_id,
    output logic [PRIO_W:0]         run_prio
);

    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam rprio_t IDLE = idle_prio(PRIO_W);
    localparam logic [N_SRC-1:0] ONE = N_SRC'(1);

    logic [N_SRC-1:0] pend, act, act_set, act_clr;
    cand_t            cand;
    act_ent_t         top, push_ent;
    logic             empty, full, eligible, ack_take, eoi_ok;
    logic [CNT_W-1:0] depth_cnt;
    rprio_t           run;

    irq_src_state #(.N_SRC(N_SRC)) u_src (
        .clk       (clk),
        .rst       (rst),
        .req_i     (src_req),
        .act_set_i (act_set),
        .act_clr_i (act_clr),
        .pend_o    (pend),
        .act_o     (act)
    );

    irq_arbiter #(.N_SRC(N_SRC), .PRIO_W(PRIO_W)) u_arb (
        .mask_i (pend & src_en),
        .prio_i (src_prio),
        .cand_o (cand)
    );

    irq_active_stack #(.DEPTH(DEPTH)) u_stk (
        .clk        (clk),
        .rst        (rst),
        .push_i     (ack_take),
        .push_ent_i (push_ent),
        .pop_i      (eoi_ok),
        .empty_o    (empty),
        .full_o     (full),
        .top_o      (top),
        .count_o    (depth_cnt)
    );

    assign run      = empty ? IDLE : rprio_t'(top.prio);
    assign eligible = cand_preempts(cand, run) && !full;
    assign ack_take = ack_rd && eligible;
    assign eoi_ok   = eoi_wr && !ack_take && !empty && (eoi_id == top.id);

    assign push_ent.id   = cand.id;
    assign push_ent.prio = cand.prio;

    assign act_set = ack_take ? (ONE << cand.id) : '0;
    assign act_clr = eoi_ok   ? (ONE << top.id)  : '0;

    assign irq_o    = eligible;
    assign ack_id   = eligible ? cand.id : SPURIOUS_ID;
    assign run_prio = run[PRIO_W:0];

    // Running priority follows the source just acknowledged (R5)
    assert_ack_sets_run_R5: assert property (@(posedge clk) disable iff (rst)
        ack_take |=> (run == $past(rprio_t'(cand.prio))));

    // In-service flags and nesting depth stay in step (R8)
    assert_depth_matches_R8: assert property (@(posedge clk) disable iff (rst)
        $countones(act) == int'(depth_cnt));

    // Interrupt line only with an enabled waiting source (R4)
    assert_irq_has_source_R4: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> ((pend & src_en) != '0));

    // Spurious acknowledge leaves service state alone (R6)
    assert_spurious_quiet_R6: assert property (@(posedge clk) disable iff (rst)
        (ack_rd && !irq_o && !eoi_wr) |=> ($stable(act) && $stable(run)));

    // Non-matching end-of-interrupt is ignored (R9)
    assert_bad_eoi_ignored_R9: assert property (@(posedge clk) disable iff (rst)
        (eoi_wr && !ack_rd && (empty || eoi_id != top.id)) |=> ($stable(act) && $stable(run)));

    // Same-edge acknowledge wins over retirement (R11)
    assert_same_edge_R11: assert property (@(posedge clk) disable iff (rst)
        (ack_take && eoi_wr) |=> ($countones(act) == $past($countones(act)) + 1));

endmodule

// File: tb/irq_cpu_if_test.sv
module irq_cpu_if_test;

    localparam int CLK_PERIOD = 10;
    localparam int N    = 8;
    localparam int PW   = 4;
    localparam int IDLE = 16;
    localparam int SPUR = 1023;

    logic          clk = 1'b0;
    logic          rst;
    logic [N-1:0]  src_req, src_en;
    logic [N*PW-1:0] src_prio;
    logic          irq_o, ack_rd, eoi_wr;
    logic [9:0]    ack_id, eoi_id;
    logic [PW:0]   run_prio;
    int            prio [N];
    int            checks = 0;
    int            errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    always_comb
        for (int i = 0; i < N; i++)
            src_prio[i*PW +: PW] = PW'(prio[i]);

    irq_cpu_if #(.N_SRC(N), .PRIO_W(PW), .DEPTH(4)) uut (
        .clk(clk), .rst(rst), .src_req(src_req), .src_en(src_en),
        .src_prio(src_prio), .irq_o(irq_o), .ack_rd(ack_rd), .ack_id(ack_id),
        .eoi_wr(eoi_wr), .eoi_id(eoi_id), .run_prio(run_prio)
    );

    task automatic check(string tag, int actual, int expected);
        checks++;
        if (actual !== expected) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, actual, expected);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        #1;
    endtask

    task automatic do_ack(output int id);
        ack_rd = 1'b1;
        #(CLK_PERIOD/2 - 2) id = int'(ack_id);
        @(negedge clk);
        ack_rd = 1'b0;
        #1;
    endtask

    task automatic do_eoi(int id);
        eoi_wr = 1'b1;
        eoi_id = 10'(id);
        @(negedge clk);
        eoi_wr = 1'b0;
        #1;
    endtask

    task automatic t_reset();
        check("R1 irq after reset", int'(irq_o), 0);
        check("R1 run_prio after reset", int'(run_prio), IDLE);
        check("R1 ack_id after reset", int'(ack_id), SPUR);
    endtask

    task automatic t_basic();
        int id;
        prio[3] = 5;
        src_req[3] = 1'b1;
        step();
        check("R2 irq one edge after request", int'(irq_o), 1);
        check("R3 offered id single source", int'(ack_id), 3);
        do_ack(id);
        check("R5 ack returns id", id, 3);
        check("R5 irq drops after ack", int'(irq_o), 0);
        check("R5 run_prio after ack", int'(run_prio), 5);
        src_req[3] = 1'b0;
        do_eoi(3);
        check("R8 run_prio idle after eoi", int'(run_prio), IDLE);
        check("R8 irq low after eoi", int'(irq_o), 0);
    endtask

    task automatic t_priority();
        int id;
        prio[1] = 7; prio[4] = 3; prio[6] = 3; prio[0] = 2;
        src_req[1] = 1'b1; src_req[4] = 1'b1; src_req[6] = 1'b1;
        step();
        check("R3 tie goes to lower id", int'(ack_id), 4);
        do_ack(id);
        check("R3 ack returns winner", id, 4);
        check("R7 equal and lower not signalled", int'(irq_o), 0);
        src_req[0] = 1'b1;
        step();
        check("R7 higher priority preempts irq", int'(irq_o), 1);
        check("R7 higher priority offered", int'(ack_id), 0);
        do_ack(id);
        check("R7 nested ack id", id, 0);
        check("R7 nested run_prio", int'(run_prio), 2);
        do_eoi(4);
        check("R9 outer eoi ignored", int'(run_prio), 2);
        do_eoi(5);
        check("R9 inactive eoi ignored", int'(run_prio), 2);
        src_req[0] = 1'b0;
        do_eoi(0);
        check("R8 run_prio restored", int'(run_prio), 3);
        check("R7 irq low at restored level", int'(irq_o), 0);
        do_eoi(4);
        check("R8 run_prio idle", int'(run_prio), IDLE);
        check("R8 still-requested source signalled again", int'(irq_o), 1);
        check("R8 still-requested source offered again", int'(ack_id), 4);
        src_req = '0;
        step();
    endtask

    task automatic t_spurious();
        int id;
        do_ack(id);
        check("R6 spurious id", id, SPUR);
        check("R6 run_prio unchanged", int'(run_prio), IDLE);
        check("R6 irq stays low", int'(irq_o), 0);
    endtask

    task automatic t_enable();
        int id;
        src_en[2] = 1'b0;
        prio[2] = 1;
        src_req[2] = 1'b1;
        step();
        check("R4 disabled source no irq", int'(irq_o), 0);
        check("R4 disabled source not offered", int'(ack_id), SPUR);
        do_ack(id);
        check("R4 ack of disabled source spurious", id, SPUR);
        check("R4 no service entered", int'(run_prio), IDLE);
        src_en[2] = 1'b1;
        #1;
        check("R4 enable makes held request eligible", int'(irq_o), 1);
        check("R4 enabled source offered", int'(ack_id), 2);
        src_req[2] = 1'b0;
        @(negedge clk);
        #1;
    endtask

    task automatic t_depth();
        int id;
        prio[0] = 8; prio[1] = 6; prio[2] = 4; prio[3] = 2; prio[5] = 1;
        for (int k = 0; k < 4; k++) begin
            src_req[k] = 1'b1;
            step();
            do_ack(id);
            check("R10 nested ack fills depth", id, k);
        end
        check("R10 run_prio at full depth", int'(run_prio), 2);
        src_req[5] = 1'b1;
        step();
        check("R10 no irq at full depth", int'(irq_o), 0);
        check("R10 nothing offered at full depth", int'(ack_id), SPUR);
        do_ack(id);
        check("R10 ack at full depth spurious", id, SPUR);
        src_req = '0;
        do_eoi(3);
        check("R8 unwind to level 4", int'(run_prio), 4);
        do_eoi(2);
        check("R8 unwind to level 6", int'(run_prio), 6);
        do_eoi(1);
        check("R8 unwind to level 8", int'(run_prio), 8);
        do_eoi(0);
        check("R8 unwind to idle", int'(run_prio), IDLE);
    endtask

    task automatic t_same_edge();
        int id;
        prio[5] = 5; prio[7] = 1;
        src_req[5] = 1'b1;
        step();
        do_ack(id);
        check("R11 first ack", id, 5);
        src_req[7] = 1'b1;
        step();
        ack_rd = 1'b1;
        eoi_wr = 1'b1;
        eoi_id = 10'd5;
        #(CLK_PERIOD/2 - 2) id = int'(ack_id);
        @(negedge clk);
        ack_rd = 1'b0;
        eoi_wr = 1'b0;
        #1;
        check("R11 ack taken on shared edge", id, 7);
        check("R11 run_prio after shared edge", int'(run_prio), 1);
        src_req = '0;
        do_eoi(7);
        check("R11 eoi on shared edge was dropped", int'(run_prio), 5);
        do_eoi(5);
        check("R8 idle after cleanup", int'(run_prio), IDLE);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < N; i++) prio[i] = 15;
        rst = 1'b1;
        src_req = '0;
        src_en = '1;
        ack_rd = 1'b0;
        eoi_wr = 1'b0;
        eoi_id = '0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        t_reset();
        t_basic();
        t_priority();
        t_spurious();
        t_enable();
        t_depth();
        t_same_edge();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule